// File: doc/BRIEF.md
# Cache-Line Counter-Mode Seed Generator

This block produces the 128-bit counter-mode seed that a block cipher uses to encrypt or decrypt one cache line of a protected memory window. The seed is unique across lines because it carries the upper bits of the line's physical address, and unique over time because it carries a counter that is kept for each line slot and advanced on every write-back. A 64-bit session vector, latched when a session opens, fills the top of the seed.

The cache controller offers one request at a time: a line address and a flag that says whether the line is being written back or filled. In-window write-backs advance the slot counter and use the new value. In-window fills reuse the stored value. Requests outside the window are acknowledged with a one-cycle bypass pulse and produce no seed. Each seed is held on a valid/ready handshake toward the cipher. After reset, and again whenever a new session opens, a hardware sweep clears every counter. One counter is cleared per cycle, and no request is taken while the sweep runs.

Top module: `line_seed_gen`

## Requirements
- R1: After reset is released, `init_busy` stays high and `req_ready` stays low for exactly 256 cycles while the sweep clears all 256 counters. A fill of any line afterwards reports count 0.
- R2: The seed is {session vector[63:0], tag[31:0], count[31:0]}. The tag is address bits 31..13, zero-extended to 32 bits. The counter slot is selected by address bits 12..5.
- R3: A fill request uses the stored count of its slot and leaves it unchanged, so repeated fills report the same count.
- R4: A write-back request adds one to its slot's count, stores the result and places it in the seed. A later fill of the slot reports the new value.
- R5: Counters are kept per slot. Lines with different slot bits count independently. Addresses that share slot bits but differ in tag share one counter, and each seed carries its own tag.
- R6: A request is in the window when region_lo <= address < region_hi. An out-of-window request is accepted, raises `req_bypass` for one cycle on the following cycle, produces no seed and leaves every counter unchanged.
- R7: `seed_valid` rises on the cycle after an in-window request is accepted. Seed and valid hold stable until `seed_ready` is seen, and `req_ready` stays low while a seed is pending. `req_ready` returns on the cycle after the handshake.
- R8: A `sess_start` pulse latches `sess_iv` as the new session vector, withdraws any pending seed and starts a new 256-cycle sweep that clears every counter.
- R9: While the sweep runs, `req_ready` is low and an asserted `req_valid` has no effect on any counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sess_start | input | 1 | Opens a session: latch vector, clear counters |
| sess_iv | input | 64 | Session vector sampled on `sess_start` |
| region_lo | input | 32 | First byte address of the protected window |
| region_hi | input | 32 | First byte address past the protected window |
| req_valid | input | 1 | Line request offered |
| req_addr | input | 32 | Physical byte address of the line |
| req_wb | input | 1 | 1 = write-back, 0 = fill |
| req_ready | output | 1 | Request taken on this cycle when `req_valid` is high |
| req_bypass | output | 1 | One-cycle pulse: the accepted request was outside the window |
| seed_valid | output | 1 | Seed presented to the cipher |
| seed_data | output | 128 | Seed {vector, tag, count} |
| seed_ready | input | 1 | Cipher takes the seed |
| init_busy | output | 1 | Counter sweep in progress |

## Verification
The counters are driven by chains of write-backs and fills on one slot, by a second slot next to it, and by an address that differs only in tag. These patterns separate a counter that is kept per slot from one that is shared or kept per address, and a count that advances on write-back from one that advances on every access. Window membership is probed just below, exactly at the lower bound and exactly at the upper bound, which catches errors in the comparison. A seed is held against a withheld ready to show it stays stable. A session restart is issued while a seed is pending and a request is held through the sweep, which shows that the pending seed is withdrawn, the counters are cleared and the held request is ignored. A behavioural model checks the outputs on every cycle alongside these targeted checks.

// File: rtl/lsg_pkg.sv
// Shared definitions for the line seed generator.
// Assumes: defaults describe a 32-bit address, 32-byte lines, 256 slots.
package lsg_pkg;
    localparam int unsigned ADDR_W_D = 32;
    localparam int unsigned OFS_W_D  = 5;
    localparam int unsigned IDX_W_D  = 8;
    localparam int unsigned TAG_W_D  = 32;
    localparam int unsigned CNT_W_D  = 32;
    localparam int unsigned IV_W_D   = 64;

    // Request controller state.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } lsg_state_e;
endpackage

// File: rtl/lsg_line_decode.sv
// Splits a line address into slot index and tag, and tests it against the window.
// Assumes: window is region_lo inclusive, region_hi exclusive; purely combinational.
module lsg_line_decode #(
    parameter int unsigned ADDR_W = lsg_pkg::ADDR_W_D,
    parameter int unsigned OFS_W  = lsg_pkg::OFS_W_D,
    parameter int unsigned IDX_W  = lsg_pkg::IDX_W_D,
    parameter int unsigned TAG_W  = lsg_pkg::TAG_W_D
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    output logic              in_rgn,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    localparam int unsigned TAG_LSB = OFS_W + IDX_W;

    // Field extraction and window comparison.
    always_comb begin
        idx    = addr[TAG_LSB-1:OFS_W];
        tag    = TAG_W'(addr >> TAG_LSB);
        in_rgn = (addr >= lo) && (addr < hi);
    end
endmodule

// File: rtl/lsg_count_mem.sv
// Per-slot counter store: one combinational read port, one write port
// shared by the clearing sweep (priority) and the request controller.
// Assumes: the two writers are never active together; contents need no reset
// because the sweep clears them.
module lsg_count_mem #(
    parameter int unsigned IDX_W = lsg_pkg::IDX_W_D,
    parameter int unsigned CNT_W = lsg_pkg::CNT_W_D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [CNT_W-1:0] cnt_q [DEPTH];

    // Write: sweep clear takes priority over an update.
    always_ff @(posedge clk) begin
        if (clr_en) begin
            cnt_q[clr_idx] <= '0;
        end else if (wr_en) begin
            cnt_q[wr_idx] <= wr_data;
        end
    end

    // Read of the addressed slot.
    assign rd_data = cnt_q[rd_idx];

    assert_port_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> !wr_en)
        else $error("counter written by request during sweep");
endmodule

// File: rtl/lsg_init_sweep.sv
// Clearing sequencer: after reset or a start pulse, walks every slot once,
// one per cycle, and reports busy meanwhile.
// Assumes: a start pulse during a sweep restarts it from slot 0.
module lsg_init_sweep #(
    parameter int unsigned IDX_W = lsg_pkg::IDX_W_D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx
);
    localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

    logic             busy_q;
    logic [IDX_W-1:0] idx_q;

    // Sweep position and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
        end else if (busy_q) begin
            if (idx_q == LAST) begin
                busy_q <= 1'b0;
            end
            idx_q <= idx_q + 1'b1;
        end
    end

    assign busy    = busy_q;
    assign clr_en  = busy_q && !start;
    assign clr_idx = idx_q;

    assert_sweep_ends_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && (idx_q == LAST) && !start |=> !busy_q)
        else $error("sweep did not end after last slot");

    assert_sweep_steps_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !start |=> idx_q == $past(idx_q) + 1'b1)
        else $error("sweep skipped a slot");
endmodule

// File: rtl/lsg_seed_ctrl.sv
// Request controller: takes one request at a time, updates the slot counter
// on write-back, forms the seed and holds it until the cipher takes it.
// Out-of-window requests only yield a bypass pulse.
// Assumes: rd_data reflects the slot of the request presented this cycle.
module lsg_seed_ctrl #(
    parameter int unsigned TAG_W = lsg_pkg::TAG_W_D,
    parameter int unsigned CNT_W = lsg_pkg::CNT_W_D,
    parameter int unsigned IV_W  = lsg_pkg::IV_W_D,
    localparam int unsigned SEED_W = IV_W + TAG_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sess_start,
    input  logic              busy,
    input  logic              req_valid,
    input  logic              req_wb,
    input  logic              in_rgn,
    input  logic [TAG_W-1:0]  tag,
    input  logic [IV_W-1:0]   iv,
    input  logic [CNT_W-1:0]  rd_data,
    output logic              req_ready,
    output logic              wr_en,
    output logic [CNT_W-1:0]  wr_data,
    output logic              req_bypass,
    output logic              seed_valid,
    output logic [SEED_W-1:0] seed_data,
    input  logic              seed_ready
);
    import lsg_pkg::*;

    lsg_state_e        state_q;
    logic [SEED_W-1:0] seed_q;
    logic              byp_q;
    logic              accept;
    logic [CNT_W-1:0]  cnt_use;

    // Acceptance and counter update for the presented request.
    always_comb begin
        req_ready = !busy && (state_q == ST_IDLE) && !sess_start;
        accept    = req_valid && req_ready;
        wr_data   = rd_data + 1'b1;
        wr_en     = accept && in_rgn && req_wb;
        cnt_use   = req_wb ? wr_data : rd_data;
    end

    // Seed register, hold state and bypass pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            seed_q  <= '0;
            byp_q   <= 1'b0;
        end else begin
            byp_q <= accept && !in_rgn;
            if (sess_start) begin
                state_q <= ST_IDLE;
            end else begin
                case (state_q)
                    ST_IDLE: if (accept && in_rgn) begin
                        seed_q  <= {iv, tag, cnt_use};
                        state_q <= ST_HOLD;
                    end
                    ST_HOLD: if (seed_ready) begin
                        state_q <= ST_IDLE;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign seed_valid = (state_q == ST_HOLD);
    assign seed_data  = seed_q;
    assign req_bypass = byp_q;

    assert_seed_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seed_valid && !seed_ready && !sess_start |=> seed_valid && $stable(seed_data))
        else $error("pending seed changed or dropped");

    assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seed_valid |-> !req_ready)
        else $error("request taken while seed pending");

    assert_refuse_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready)
        else $error("request taken during sweep");

    assert_bypass_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({seed_valid, req_bypass}))
        else $error("bypass pulse together with a seed");
endmodule

// File: rtl/line_seed_gen.sv
// Top: cache-line counter-mode seed generator. Holds the session vector and
// ties together decode, counter store, clearing sweep and request control.
// Assumes: one request outstanding at a time; window bounds held steady.
module line_seed_gen #(
    parameter int unsigned ADDR_W = lsg_pkg::ADDR_W_D,
    parameter int unsigned OFS_W  = lsg_pkg::OFS_W_D,
    parameter int unsigned IDX_W  = lsg_pkg::IDX_W_D,
    parameter int unsigned TAG_W  = lsg_pkg::TAG_W_D,
    parameter int unsigned CNT_W  = lsg_pkg::CNT_W_D,
    parameter int unsigned IV_W   = lsg_pkg::IV_W_D,
    localparam int unsigned SEED_W = IV_W + TAG_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sess_start,
    input  logic [IV_W-1:0]   sess_iv,
    input  logic [ADDR_W-1:0] region_lo,
    input  logic [ADDR_W-1:0] region_hi,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wb,
    output logic              req_ready,
    output logic              req_bypass,
    output logic              seed_valid,
    output logic [SEED_W-1:0] seed_data,
    input  logic              seed_ready,
    output logic              init_busy
);
    logic [IV_W-1:0]  iv_q;
    logic             in_rgn;
    logic [IDX_W-1:0] line_idx;
    logic [TAG_W-1:0] line_tag;
    logic             clr_en;
    logic [IDX_W-1:0] clr_idx;
    logic             wr_en;
    logic [CNT_W-1:0] wr_data;
    logic [CNT_W-1:0] rd_data;

    // Session vector register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iv_q <= '0;
        end else if (sess_start) begin
            iv_q <= sess_iv;
        end
    end

    lsg_line_decode #(
        .ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_decode (
        .addr(req_addr), .lo(region_lo), .hi(region_hi),
        .in_rgn(in_rgn), .idx(line_idx), .tag(line_tag)
    );

    lsg_init_sweep #(.IDX_W(IDX_W)) u_sweep (
        .clk(clk), .rst_n(rst_n), .start(sess_start),
        .busy(init_busy), .clr_en(clr_en), .clr_idx(clr_idx)
    );

    lsg_count_mem #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .clr_en(clr_en), .clr_idx(clr_idx),
        .wr_en(wr_en), .wr_idx(line_idx), .wr_data(wr_data),
        .rd_idx(line_idx), .rd_data(rd_data)
    );

    lsg_seed_ctrl #(.TAG_W(TAG_W), .CNT_W(CNT_W), .IV_W(IV_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sess_start(sess_start), .busy(init_busy),
        .req_valid(req_valid), .req_wb(req_wb), .in_rgn(in_rgn),
        .tag(line_tag), .iv(iv_q), .rd_data(rd_data),
        .req_ready(req_ready), .wr_en(wr_en), .wr_data(wr_data),
        .req_bypass(req_bypass), .seed_valid(seed_valid),
        .seed_data(seed_data), .seed_ready(seed_ready)
    );

    assert_iv_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sess_start |=> iv_q == $past(sess_iv))
        else $error("session vector not latched");
endmodule

// File: tb/test_line_seed_gen.sv
// Bench: behavioural reference model compared every cycle, plus targeted checks.
module test_line_seed_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sess_start = 1'b0;
    logic [63:0]  sess_iv = '0;
    logic [31:0]  region_lo = 32'h0001_0000;
    logic [31:0]  region_hi = 32'h0002_0000;
    logic         req_valid = 1'b0;
    logic [31:0]  req_addr = '0;
    logic         req_wb = 1'b0;
    logic         req_ready;
    logic         req_bypass;
    logic         seed_valid;
    logic [127:0] seed_data;
    logic         seed_ready = 1'b0;
    logic         init_busy;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    line_seed_gen i_line_seed_gen (
        .clk(clk), .rst_n(rst_n), .sess_start(sess_start), .sess_iv(sess_iv),
        .region_lo(region_lo), .region_hi(region_hi),
        .req_valid(req_valid), .req_addr(req_addr), .req_wb(req_wb),
        .req_ready(req_ready), .req_bypass(req_bypass),
        .seed_valid(seed_valid), .seed_data(seed_data),
        .seed_ready(seed_ready), .init_busy(init_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- reference model ----------------
    logic [31:0]  m_cnt [256];
    bit           m_busy, m_valid, m_byp;
    int           m_idx;
    logic [63:0]  m_iv;
    logic [127:0] m_seed;
    bit           m_rdy;

    function automatic int slot_of(logic [31:0] a);
        return int'((a >> 5) & 32'hFF);
    endfunction

    function automatic logic [127:0] mk_seed(logic [63:0] v, logic [31:0] a, logic [31:0] c);
        return {v, a >> 13, c};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b1; m_idx = 0; m_valid = 1'b0; m_byp = 1'b0; m_iv = '0;
        end else begin
            m_rdy = !m_busy && !m_valid && !sess_start;
            m_byp = 1'b0;
            if (sess_start) begin
                m_iv = sess_iv; m_busy = 1'b1; m_idx = 0; m_valid = 1'b0;
            end else if (m_busy) begin
                m_cnt[m_idx] = '0;
                if (m_idx == 255) m_busy = 1'b0;
                m_idx++;
            end else if (m_valid) begin
                if (seed_ready) m_valid = 1'b0;
            end else if (req_valid && m_rdy) begin
                if (req_addr >= region_lo && req_addr < region_hi) begin
                    if (req_wb) m_cnt[slot_of(req_addr)] = m_cnt[slot_of(req_addr)] + 1;
                    m_seed  = mk_seed(m_iv, req_addr, m_cnt[slot_of(req_addr)]);
                    m_valid = 1'b1;
                end else begin
                    m_byp = 1'b1;
                end
            end
        end
    end

    // Per-cycle comparison, a quarter period after the edge (R1, R6, R7, R9).
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (!done) begin
            bit bad;
            bad = 1'b0;
            n_checks++;
            if (init_busy !== m_busy) begin
                $display("FAIL R1 cycle %0d init_busy act=%b exp=%b", cyc, init_busy, m_busy); bad = 1'b1;
            end
            if (req_ready !== (!m_busy && !m_valid && !sess_start && rst_n)) begin
                $display("FAIL R9 cycle %0d req_ready act=%b exp=%b", cyc, req_ready,
                         (!m_busy && !m_valid && !sess_start && rst_n)); bad = 1'b1;
            end
            if (seed_valid !== m_valid) begin
                $display("FAIL R7 cycle %0d seed_valid act=%b exp=%b", cyc, seed_valid, m_valid); bad = 1'b1;
            end
            if (req_bypass !== m_byp) begin
                $display("FAIL R6 cycle %0d req_bypass act=%b exp=%b", cyc, req_bypass, m_byp); bad = 1'b1;
            end
            if (m_valid && seed_data !== m_seed) begin
                $display("FAIL R2 cycle %0d seed_data act=%h exp=%h", cyc, seed_data, m_seed); bad = 1'b1;
            end
            if (bad) n_fail++;
        end
    end

    // ---------------- helpers ----------------
    task automatic summary();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG_LIMIT && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog act=%0d exp<=%0d cycles", cyc, WDOG_LIMIT);
            summary();
        end
    end

    // Issue one request; returns the seed or the bypass flag.
    task automatic issue(input logic [31:0] a, input logic wb, input int hold,
                         output logic [127:0] sd, output logic byp);
        @(negedge clk);
        req_addr = a; req_wb = wb; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        byp = req_bypass;
        sd  = seed_data;
        if (!byp) begin
            for (int k = 0; k < hold; k++) @(negedge clk);
            if (hold > 0) begin
                chk("R7 seed held stable", seed_data, sd);
                chk("R7 ready low while pending", {127'b0, req_ready}, 128'd0);
            end
            seed_ready = 1'b1;
            @(negedge clk);
            seed_ready = 1'b0;
        end
    endtask

    localparam logic [31:0] ADR_A = 32'h0001_2340;
    localparam logic [31:0] ADR_B = 32'h0001_2360;
    localparam logic [31:0] ADR_C = 32'h0001_4340;
    localparam logic [63:0] IV2   = 64'hA5A5_0123_4567_89AB;

    initial begin
        logic [127:0] sd;
        logic         byp;
        int           n;

        repeat (3) @(negedge clk);
        chk("R1 reset busy", {127'b0, init_busy}, 128'd1);
        chk("R1 reset ready", {127'b0, req_ready}, 128'd0);
        chk("R7 reset valid", {127'b0, seed_valid}, 128'd0);
        rst_n = 1'b1;
        n = 0;
        while (init_busy) begin n++; @(negedge clk); end
        chk("R1 sweep length", 128'(n), 128'd256);

        issue(ADR_A, 1'b0, 0, sd, byp);
        chk("R1 R2 R3 first fill", sd, mk_seed(64'd0, ADR_A, 32'd0));
        issue(ADR_A, 1'b1, 0, sd, byp);
        chk("R4 write-back 1", sd, mk_seed(64'd0, ADR_A, 32'd1));
        issue(ADR_A, 1'b1, 5, sd, byp);
        chk("R4 R7 write-back 2 held", sd, mk_seed(64'd0, ADR_A, 32'd2));
        issue(ADR_A, 1'b0, 0, sd, byp);
        chk("R3 fill keeps count", sd, mk_seed(64'd0, ADR_A, 32'd2));
        issue(ADR_A, 1'b0, 2, sd, byp);
        chk("R3 repeated fill", sd, mk_seed(64'd0, ADR_A, 32'd2));
        issue(ADR_B, 1'b0, 0, sd, byp);
        chk("R5 neighbour slot independent", sd, mk_seed(64'd0, ADR_B, 32'd0));
        issue(ADR_C, 1'b1, 0, sd, byp);
        chk("R5 shared slot other tag", sd, mk_seed(64'd0, ADR_C, 32'd3));

        issue(32'h0000_FFE0, 1'b1, 0, sd, byp);
        chk("R6 below window bypass", {127'b0, byp}, 128'd1);
        issue(32'h0002_0000, 1'b1, 0, sd, byp);
        chk("R6 at upper bound bypass", {127'b0, byp}, 128'd1);
        issue(32'h0001_0000, 1'b1, 0, sd, byp);
        chk("R6 at lower bound in window", sd, mk_seed(64'd0, 32'h0001_0000, 32'd1));
        issue(32'h0000_FFE0 + 32'h0002_0000 - 32'h0001_FFE0 + ADR_A - 32'h0001_0000 + 32'h0002_0000, 1'b1, 0, sd, byp);
        chk("R6 above window bypass", {127'b0, byp}, 128'd1);
        issue(ADR_A, 1'b0, 0, sd, byp);
        chk("R6 bypass left counter", sd, mk_seed(64'd0, ADR_A, 32'd3));

        // Session restart with a seed pending and a request held through the sweep.
        @(negedge clk);
        req_addr = ADR_B; req_wb = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7 pending before restart", {127'b0, seed_valid}, 128'd1);
        sess_iv = IV2; sess_start = 1'b1;
        @(negedge clk);
        sess_start = 1'b0;
        chk("R8 pending seed withdrawn", {127'b0, seed_valid}, 128'd0);
        req_addr = ADR_A; req_wb = 1'b1; req_valid = 1'b1;
        n = 0;
        while (init_busy) begin
            n++;
            if (req_ready) chk("R9 ready during sweep", 128'd1, 128'd0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk("R8 restart sweep length", 128'(n), 128'd256);
        issue(ADR_A, 1'b0, 0, sd, byp);
        chk("R8 R9 cleared, new vector", sd, mk_seed(IV2, ADR_A, 32'd0));
        issue(ADR_B, 1'b1, 0, sd, byp);
        chk("R8 neighbour cleared", sd, mk_seed(IV2, ADR_B, 32'd1));

        repeat (3) @(negedge clk);
        summary();
    end
endmodule